// File: doc/BRIEF.md
# Load-Use Scoreboard Interlock

This block guards the decode stage of a five-stage in-order integer pipeline (fetch, decode, execute, data cache, writeback) against read-after-write hazards on results that arrive late, such as load data. It keeps one busy flag per architectural register. When an instruction marked as producing a late result leaves decode, its destination flag is raised. A later instruction that reads a flagged register waits in decode. Fetch is frozen behind it and execute is fed a bubble until the flag drops.

The flag drops on the clock edge that ends the cycle in which the producing instruction's destination index is shown on a release port. Two release ports exist: one from the data-cache stage and one from writeback. The `dc_fwd_en` input picks which one is used. When the surrounding pipeline forwards cache data back to execute, releasing from the data-cache stage saves one stall cycle. When it does not forward, the writeback port must be used. A flush wipes every flag and holds nothing. Forwarding muxes, the register file and the ALU live outside this block.

Top module: `late_result_interlock`

## Requirements
- R1: After reset every busy flag is clear, so a decoding instruction that reads any register is not held.
- R2: A decode with `id_vld`=1, `id_late`=1, `flush`=0, `id_rd`≠0 that is not held marks `id_rd` busy from the next cycle. A later instruction reading that register through either source port whose use flag is 1 is held.
- R3: `if_hold`, `id_hold` and `ex_bubble` are all 1 in exactly the cycles in which the decode inputs present a busy source with its use flag set, while `id_vld`=1 and `flush`=0. Otherwise all three are 0, in the same cycle and without a register delay.
- R4: With `dc_fwd_en`=0 a flag clears at the edge that ends the cycle in which `wb_late_vld`=1 shows its index on `wb_rd`. An instruction that decodes right behind the late producer and reads its result is held for 3 cycles.
- R5: With `dc_fwd_en`=1 the release comes from `dc_late_vld`/`dc_rd` instead, and the same back-to-back dependent is held for 2 cycles.
- R6: Register 0 is never marked busy, and reading it never causes a hold.
- R7: A source whose use flag is 0, or a decode with `id_vld`=0, never causes a hold.
- R8: On one edge, setting one register and releasing another updates both flags. When the same register is both set and released on that edge, it stays busy.
- R9: While `flush`=1 nothing is held. On that edge every flag is cleared and any set request from decode is dropped, so no hold follows from earlier producers.
- R10: A decode with `id_late`=0 marks nothing busy, so a following reader of its destination is not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Squash of in-flight instructions; clears all flags |
| dc_fwd_en | input | 1 | 1: release from data-cache port; 0: release from writeback port |
| id_vld | input | 1 | Decode holds a valid instruction |
| id_rs1 | input | IW | First source register index |
| id_rs1_use | input | 1 | First source is read |
| id_rs2 | input | IW | Second source register index |
| id_rs2_use | input | 1 | Second source is read |
| id_rd | input | IW | Destination register index |
| id_late | input | 1 | Destination value is produced late |
| dc_late_vld | input | 1 | Late producer in data-cache stage |
| dc_rd | input | IW | Its destination index |
| wb_late_vld | input | 1 | Late producer in writeback stage |
| wb_rd | input | IW | Its destination index |
| if_hold | output | 1 | Freeze fetch |
| id_hold | output | 1 | Repeat decode |
| ex_bubble | output | 1 | Send an invalid slot to execute |

## Verification
The hold outputs are combinational from the decode inputs and the flags, so they are due in the same cycle as the stimulus. The bench drives inputs just after a rising edge and samples one nanosecond later. A set or release takes effect one edge later. The bench keeps its own model of the execute, data-cache and writeback stages, which feeds the release ports. It then counts the consecutive held cycles of a dependent and compares the count with 3 (writeback release) or 2 (cache release). After each scenario, idle cycles drain the model pipeline so that no flag carries into the next test.

// File: rtl/late_result_interlock.sv
module late_result_interlock #(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          dc_fwd_en,
  input  logic          id_vld,
  input  logic [IW-1:0] id_rs1,
  input  logic          id_rs1_use,
  input  logic [IW-1:0] id_rs2,
  input  logic          id_rs2_use,
  input  logic [IW-1:0] id_rd,
  input  logic          id_late,
  input  logic          dc_late_vld,
  input  logic [IW-1:0] dc_rd,
  input  logic          wb_late_vld,
  input  logic [IW-1:0] wb_rd,
  output logic          if_hold,
  output logic          id_hold,
  output logic          ex_bubble
);

  localparam logic [NREG-1:0] ONE  = NREG'(1);
  localparam logic [NREG-1:0] KEEP = ~ONE;

  logic [NREG-1:0] busy, set_vec, clr_vec, busy_d;
  logic            rel_vld, hit, issue_late;
  logic [IW-1:0]   rel_idx;

  assign rel_vld = dc_fwd_en ? dc_late_vld : wb_late_vld;
  assign rel_idx = dc_fwd_en ? dc_rd : wb_rd;

  assign hit = (id_rs1_use & busy[id_rs1]) | (id_rs2_use & busy[id_rs2]);
  assign id_hold   = id_vld & ~flush & hit;
  assign if_hold   = id_hold;
  assign ex_bubble = id_hold;

  assign issue_late = id_vld & id_late & ~id_hold & ~flush;
  assign set_vec = issue_late ? (ONE << id_rd) : '0;
  assign clr_vec = rel_vld ? (ONE << rel_idx) : '0;
  assign busy_d  = flush ? '0 : (((busy & ~clr_vec) | set_vec) & KEEP);

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= '0;
    else        busy <= busy_d;
  end

endmodule

module late_result_interlock_chk #(
  parameter int NREG = 32,
  localparam int IW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          id_vld,
  input logic [IW-1:0] id_rs1,
  input logic          id_rs1_use,
  input logic [IW-1:0] id_rs2,
  input logic          id_rs2_use,
  input logic [IW-1:0] id_rd,
  input logic          id_late,
  input logic          if_hold,
  input logic          id_hold,
  input logic          ex_bubble
);

  assert_set_then_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(id_vld && id_late && !id_hold && !flush && id_rd != '0)
     && id_vld && !flush && id_rs1_use && id_rs1 == $past(id_rd)) |-> id_hold);

  assert_zero_reg_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_vld && (!id_rs1_use || id_rs1 == '0) && (!id_rs2_use || id_rs2 == '0))
    |-> !id_hold);

  assert_idle_no_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !id_vld |-> (!id_hold && !if_hold && !ex_bubble));

  assert_flush_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !id_hold);

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !id_hold);

endmodule

bind late_result_interlock late_result_interlock_chk #(.NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .id_vld(id_vld),
  .id_rs1(id_rs1), .id_rs1_use(id_rs1_use), .id_rs2(id_rs2), .id_rs2_use(id_rs2_use),
  .id_rd(id_rd), .id_late(id_late), .if_hold(if_hold), .id_hold(id_hold),
  .ex_bubble(ex_bubble)
);

// File: tb/late_result_interlock_tb_top.sv
`timescale 1ns/1ps
module late_result_interlock_tb_top;
  localparam int NREG = 32;
  localparam int IW = $clog2(NREG);

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, dc_fwd_en = 1'b0;
  logic id_vld = 1'b0, id_rs1_use = 1'b0, id_rs2_use = 1'b0, id_late = 1'b0;
  logic [IW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic ex_v, dc_v, wb_v;
  logic [IW-1:0] ex_rd, dc_rd, wb_rd;
  logic if_hold, id_hold, ex_bubble;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  late_result_interlock #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .dc_fwd_en(dc_fwd_en),
    .id_vld(id_vld), .id_rs1(id_rs1), .id_rs1_use(id_rs1_use),
    .id_rs2(id_rs2), .id_rs2_use(id_rs2_use), .id_rd(id_rd), .id_late(id_late),
    .dc_late_vld(dc_v), .dc_rd(dc_rd), .wb_late_vld(wb_v), .wb_rd(wb_rd),
    .if_hold(if_hold), .id_hold(id_hold), .ex_bubble(ex_bubble)
  );

  // bench model of the stages behind decode
  always @(posedge clk) begin
    if (!rst_n) begin
      ex_v <= 1'b0; dc_v <= 1'b0; wb_v <= 1'b0;
      ex_rd <= '0; dc_rd <= '0; wb_rd <= '0;
    end else begin
      ex_v <= id_vld && id_late && !id_hold && !flush; ex_rd <= id_rd;
      dc_v <= ex_v && !flush; dc_rd <= ex_rd;
      wb_v <= dc_v && !flush; wb_rd <= dc_rd;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drv(bit v, int rs1, bit u1, int rs2, bit u2, int rd, bit late);
    id_vld = v; id_rs1 = IW'(rs1); id_rs1_use = u1; id_rs2 = IW'(rs2);
    id_rs2_use = u2; id_rd = IW'(rd); id_late = late;
  endtask

  task automatic idle(int n);
    drv(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic count_hold(output int n);
    n = 0; #1;
    while (id_hold && n < 10) begin
      n++;
      check("R3 if_hold follows hold", if_hold, 1);
      check("R3 ex_bubble follows hold", ex_bubble, 1);
      step(); #1;
    end
    check("R3 outputs low after hold", {if_hold, ex_bubble}, 0);
  endtask

  task automatic t_reset();
    drv(1, 5, 1, 9, 1, 1, 0); #1;
    check("R1 no hold after reset", id_hold, 0);
    step(); idle(5);
  endtask

  task automatic t_dep(bit fwd, bit use_rs2, int exp);
    int n;
    dc_fwd_en = fwd;
    drv(1, 0, 0, 0, 0, 2, 1); #1;
    check("R2 producer not held", id_hold, 0);
    step();
    if (use_rs2) drv(1, 0, 0, 2, 1, 3, 0);
    else         drv(1, 2, 1, 0, 0, 3, 0);
    count_hold(n);
    check(fwd ? "R5 cache release stall" : (use_rs2 ? "R2 rs2 stall R4" : "R4 writeback release stall"), n, exp);
    step(); idle(6);
  endtask

  task automatic t_zero();
    dc_fwd_en = 0;
    drv(1, 0, 0, 0, 0, 0, 1); step();
    drv(1, 0, 1, 0, 1, 4, 0); #1;
    check("R6 register 0 never busy", id_hold, 0);
    step(); idle(6);
  endtask

  task automatic t_unused();
    dc_fwd_en = 0;
    drv(1, 0, 0, 0, 0, 11, 1); step();
    drv(0, 11, 1, 11, 1, 4, 0); #1;
    check("R7 invalid decode", id_hold + if_hold + ex_bubble, 0);
    step();
    drv(1, 11, 0, 11, 0, 4, 0); #1;
    check("R7 use flags low", id_hold, 0);
    step(); idle(6);
  endtask

  task automatic t_same_edge();
    int n;
    dc_fwd_en = 0;
    drv(1, 0, 0, 0, 0, 3, 1); step();
    idle(2);
    drv(1, 0, 0, 0, 0, 3, 1); #1;
    check("R8 reload not held", id_hold, 0);
    step();
    drv(1, 3, 1, 0, 0, 6, 0);
    count_hold(n);
    check("R8 set wins over release", n, 3);
    step(); idle(6);
    drv(1, 0, 0, 0, 0, 4, 1); step();
    idle(2);
    drv(1, 0, 0, 0, 0, 5, 1); step();
    drv(1, 4, 1, 0, 0, 6, 0); #1;
    check("R8 other register released", id_hold, 0);
    step();
    drv(1, 0, 0, 5, 1, 6, 0);
    count_hold(n);
    check("R8 other register set", n, 2);
    step(); idle(6);
  endtask

  task automatic t_flush();
    dc_fwd_en = 0;
    drv(1, 0, 0, 0, 0, 8, 1); step();
    flush = 1; drv(1, 8, 1, 0, 0, 9, 1); #1;
    check("R9 no hold during flush", id_hold, 0);
    step(); flush = 0;
    drv(1, 8, 1, 9, 1, 6, 0); #1;
    check("R9 flags cleared by flush", id_hold, 0);
    step(); idle(6);
  endtask

  task automatic t_not_late();
    dc_fwd_en = 1;
    drv(1, 0, 0, 0, 0, 10, 0); step();
    drv(1, 10, 1, 10, 1, 6, 0); #1;
    check("R10 non-late write not busy", id_hold, 0);
    step(); idle(6);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_dep(0, 0, 3);
    t_dep(0, 1, 3);
    t_dep(1, 0, 2);
    t_dep(1, 1, 2);
    t_zero();
    t_unused();
    t_same_edge();
    t_flush();
    t_not_late();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule